// File: doc/BRIEF.md
# 32-bit Base Integer Instruction Decoder

This block turns one 32-bit base-integer instruction word into the signals the next pipeline stage needs. It sorts the word into one of six encoding formats using only opcode bits 6:2. It rebuilds the sign-extended 32-bit immediate for that format, and it pulls out the register indices and function fields. It also gives a separate match flag for each conditional branch kind, for add-immediate and for register add. Each extracted field has its own valid flag, and a field whose flag is low is forced to zero so that later stages never see leftover bits.

Control logic classifies the word and produces a small set of strobes. A datapath uses those strobes to steer the immediate and to mask the fields. The output stage is chosen by a parameter. By default it is a register stage that clears on reset, which gives the block one clock of latency. The other choice is a plain pass-through.

Top module: `instr_decoder`

## Requirements
- R1: The format vector `fmtOneHot` uses bit 0 = R, 1 = I, 2 = S, 3 = B, 4 = U and 5 = J, decoded from instr[6:2] alone. R is 01011, 01100, 01110 or 10100. I is 00000, 00001, 00100, 00110 or 11001. S is 01000 or 01001. B is 11000. U is 00101 or 01101. J is 11011. Every other value sets no bit.
- R2: At most one bit of `fmtOneHot` is ever set.
- R3: For the I format, the immediate is instr[31:20] sign-extended. For the S format, it is {instr[31:25], instr[11:7]} sign-extended.
- R4: For the B format, the immediate is {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended. For the U format, it is instr[31:12] with 12 zero bits below. For the J format, it is {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended. When no format bit is set, the immediate is zero.
- R5: When its valid flag is high, each field carries these bits: rs1 = instr[19:15], rs2 = instr[24:20], rd = instr[11:7], funct3 = instr[14:12] and funct7 = instr[31:25]. The opcode output always carries instr[6:0].
- R6: rs1 and funct3 are valid for R, I, S and B. rs2 is valid for R, S and B. rd is valid for R, I, U and J. funct7 is valid only for R.
- R7: A field whose valid flag is low is output as zero, whatever the instruction bits hold.
- R8: `brMatch` bits 0 to 5 flag equal, not-equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. They match when instr[6:0] = 1100011 and instr[14:12] is 000, 001, 100, 101, 110 or 111 in that bit order. instr[30] is ignored.
- R9: `isAddImm` is set for instr[6:0] = 0010011 with instr[14:12] = 000, whatever instr[30] holds. `isAddReg` is set for instr[6:0] = 0110011 with instr[14:12] = 000 and instr[30] = 0. The other funct7 bits are not examined.
- R10: With the register stage (the default), outputs reflect the instruction sampled at the previous rising clock edge. An active-low `rstN` clears every output to zero at once and holds it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| instrIn | input | 32 | Instruction word to decode |
| fmtOneHot | output | 6 | Encoding format, one bit per format |
| immOut | output | 32 | Sign-extended immediate |
| rs1Out | output | 5 | First source register index |
| rs2Out | output | 5 | Second source register index |
| rdOut | output | 5 | Destination register index |
| funct3Out | output | 3 | Three-bit function field |
| funct7Out | output | 7 | Seven-bit function field |
| opcodeOut | output | 7 | Opcode bits 6:0 |
| rs1Vld | output | 1 | rs1Out is meaningful |
| rs2Vld | output | 1 | rs2Out is meaningful |
| rdVld | output | 1 | rdOut is meaningful |
| funct3Vld | output | 1 | funct3Out is meaningful |
| funct7Vld | output | 1 | funct7Out is meaningful |
| brMatch | output | 6 | Conditional branch kind match flags |
| isAddImm | output | 1 | Add-immediate match |
| isAddReg | output | 1 | Register add match |

## Verification
Some properties are checked on every cycle: the format vector is at most one-hot, and each field is zero whenever its valid flag is low. The valid flags must agree with the format, a branch match may appear only with the B format, and the two add flags are never set together. The B and J immediates must be even and the U immediate must have its low 12 bits clear. The opcode must follow the input one cycle later, and reset must clear the outputs. Some things only the bench's scenarios can show, because they depend on the exact bit mapping of each input word. These are the exact immediate bit order for each format, which wildcard codes land in which format, and that instr[30] separates register add from other words but not add-immediate. The bench checks them against a behavioural model fed with directed words for all 32 opcode groups and with many random words.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int F3_W = 3;
  localparam int F7_W = 7;
  localparam int OPC_W = 7;
  localparam int N_FMT = 6;
  localparam int N_BR = 6;

  localparam int FMT_R = 0;
  localparam int FMT_I = 1;
  localparam int FMT_S = 2;
  localparam int FMT_B = 3;
  localparam int FMT_U = 4;
  localparam int FMT_J = 5;

  // funct3 code per branch match bit, bit 0 in the lowest slice
  localparam logic [N_BR*F3_W-1:0] BR_F3_CODES =
    {3'b111, 3'b110, 3'b101, 3'b100, 3'b001, 3'b000};
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_ALU_IMM = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_ALU_REG = 7'b0110011;

  typedef struct packed {
    logic [N_FMT-1:0] fmt;
    logic rs1Vld;
    logic rs2Vld;
    logic rdVld;
    logic f3Vld;
    logic f7Vld;
    logic [N_BR-1:0] br;
    logic addImm;
    logic addReg;
  } ctrlStrb_t;

  typedef struct packed {
    logic [N_FMT-1:0] fmt;
    logic [INSTR_W-1:0] imm;
    logic [REG_IDX_W-1:0] rs1;
    logic [REG_IDX_W-1:0] rs2;
    logic [REG_IDX_W-1:0] rd;
    logic [F3_W-1:0] f3;
    logic [F7_W-1:0] f7;
    logic [OPC_W-1:0] opc;
    logic rs1Vld;
    logic rs2Vld;
    logic rdVld;
    logic f3Vld;
    logic f7Vld;
    logic [N_BR-1:0] br;
    logic addImm;
    logic addReg;
  } decOut_t;
endpackage

// File: rtl/instr_decoder_ctrl.sv
module instr_decoder_ctrl
  import instr_decoder_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrlStrb_t          strb
);
  logic [4:0] opGrp;
  logic [F3_W+OPC_W:0] matchKey;   // {funct7[5], funct3, opcode}
  logic [N_FMT-1:0] fmt;
  logic [N_BR-1:0] brHit;

  assign opGrp = instr[6:2];
  assign matchKey = {instr[30], instr[14:12], instr[6:0]};

  always_comb begin
    fmt = '0;
    fmt[FMT_U] = (opGrp ==? 5'b0?101);
    fmt[FMT_S] = (opGrp ==? 5'b0100?);
    fmt[FMT_J] = (opGrp ==? 5'b11011);
    fmt[FMT_B] = (opGrp ==? 5'b11000);
    fmt[FMT_R] = (opGrp ==? 5'b01011) || (opGrp ==? 5'b011?0) || (opGrp ==? 5'b10100);
    fmt[FMT_I] = (opGrp ==? 5'b0000?) || (opGrp ==? 5'b001?0) || (opGrp ==? 5'b11001);
  end

  // one comparator per branch kind; bit 30 of the word is left out of the key
  for (genvar g = 0; g < N_BR; g++) begin : g_brKey
    assign brHit[g] = (matchKey[F3_W+OPC_W-1:0] == {BR_F3_CODES[g*F3_W +: F3_W], OPC_BRANCH});
  end

  always_comb begin
    strb.fmt    = fmt;
    strb.rs1Vld = fmt[FMT_R] | fmt[FMT_I] | fmt[FMT_S] | fmt[FMT_B];
    strb.f3Vld  = fmt[FMT_R] | fmt[FMT_I] | fmt[FMT_S] | fmt[FMT_B];
    strb.rs2Vld = fmt[FMT_R] | fmt[FMT_S] | fmt[FMT_B];
    strb.rdVld  = fmt[FMT_R] | fmt[FMT_I] | fmt[FMT_U] | fmt[FMT_J];
    strb.f7Vld  = fmt[FMT_R];
    strb.br     = brHit;
    strb.addImm = (matchKey[F3_W+OPC_W-1:0] == {3'b000, OPC_ALU_IMM});
    strb.addReg = (matchKey == {1'b0, 3'b000, OPC_ALU_REG});
  end
endmodule

// File: rtl/instr_decoder_dp.sv
module instr_decoder_dp
  import instr_decoder_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  ctrlStrb_t          strb,
  output decOut_t            dec
);
  logic sgn;
  logic [INSTR_W-1:0] immSel;

  assign sgn = instr[31];

  always_comb begin
    immSel = '0;
    case (1'b1)
      strb.fmt[FMT_I]: immSel = {{21{sgn}}, instr[30:20]};
      strb.fmt[FMT_S]: immSel = {{21{sgn}}, instr[30:25], instr[11:7]};
      strb.fmt[FMT_B]: immSel = {{20{sgn}}, instr[7], instr[30:25], instr[11:8], 1'b0};
      strb.fmt[FMT_U]: immSel = {instr[31:12], 12'b0};
      strb.fmt[FMT_J]: immSel = {{12{sgn}}, instr[19:12], instr[20], instr[30:21], 1'b0};
      default:         immSel = '0;
    endcase
  end

  always_comb begin
    dec.fmt    = strb.fmt;
    dec.imm    = immSel;
    dec.rs1    = strb.rs1Vld ? instr[19:15] : '0;
    dec.rs2    = strb.rs2Vld ? instr[24:20] : '0;
    dec.rd     = strb.rdVld  ? instr[11:7]  : '0;
    dec.f3     = strb.f3Vld  ? instr[14:12] : '0;
    dec.f7     = strb.f7Vld  ? instr[31:25] : '0;
    dec.opc    = instr[6:0];
    dec.rs1Vld = strb.rs1Vld;
    dec.rs2Vld = strb.rs2Vld;
    dec.rdVld  = strb.rdVld;
    dec.f3Vld  = strb.f3Vld;
    dec.f7Vld  = strb.f7Vld;
    dec.br     = strb.br;
    dec.addImm = strb.addImm;
    dec.addReg = strb.addReg;
  end
endmodule

// File: rtl/instr_decoder_stage.sv
module instr_decoder_stage
  import instr_decoder_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  decOut_t dIn,
  output decOut_t dOut
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dOut <= '0;
      else       dOut <= dIn;
    end
  end else begin : g_wire
    assign dOut = dIn;
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_decoder_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   instrIn,
  output logic [N_FMT-1:0]     fmtOneHot,
  output logic [INSTR_W-1:0]   immOut,
  output logic [REG_IDX_W-1:0] rs1Out,
  output logic [REG_IDX_W-1:0] rs2Out,
  output logic [REG_IDX_W-1:0] rdOut,
  output logic [F3_W-1:0]      funct3Out,
  output logic [F7_W-1:0]      funct7Out,
  output logic [OPC_W-1:0]     opcodeOut,
  output logic                 rs1Vld,
  output logic                 rs2Vld,
  output logic                 rdVld,
  output logic                 funct3Vld,
  output logic                 funct7Vld,
  output logic [N_BR-1:0]      brMatch,
  output logic                 isAddImm,
  output logic                 isAddReg
);
  ctrlStrb_t strb;
  decOut_t   decComb;
  decOut_t   decQ;

  instr_decoder_ctrl u_ctrl (.instr(instrIn), .strb(strb));
  instr_decoder_dp   u_dp   (.instr(instrIn), .strb(strb), .dec(decComb));
  instr_decoder_stage #(.OUT_REG(OUT_REG)) u_stage (
    .clk(clk), .rstN(rstN), .dIn(decComb), .dOut(decQ)
  );

  assign fmtOneHot = decQ.fmt;
  assign immOut    = decQ.imm;
  assign rs1Out    = decQ.rs1;
  assign rs2Out    = decQ.rs2;
  assign rdOut     = decQ.rd;
  assign funct3Out = decQ.f3;
  assign funct7Out = decQ.f7;
  assign opcodeOut = decQ.opc;
  assign rs1Vld    = decQ.rs1Vld;
  assign rs2Vld    = decQ.rs2Vld;
  assign rdVld     = decQ.rdVld;
  assign funct3Vld = decQ.f3Vld;
  assign funct7Vld = decQ.f7Vld;
  assign brMatch   = decQ.br;
  assign isAddImm  = decQ.addImm;
  assign isAddReg  = decQ.addReg;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk
  import instr_decoder_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [INSTR_W-1:0]   instrIn,
  input logic [N_FMT-1:0]     fmtOneHot,
  input logic [INSTR_W-1:0]   immOut,
  input logic [REG_IDX_W-1:0] rs1Out,
  input logic [REG_IDX_W-1:0] rs2Out,
  input logic [REG_IDX_W-1:0] rdOut,
  input logic [F3_W-1:0]      funct3Out,
  input logic [F7_W-1:0]      funct7Out,
  input logic [OPC_W-1:0]     opcodeOut,
  input logic                 rs1Vld,
  input logic                 rs2Vld,
  input logic                 rdVld,
  input logic                 funct3Vld,
  input logic                 funct7Vld,
  input logic [N_BR-1:0]      brMatch,
  input logic                 isAddImm,
  input logic                 isAddReg
);
  p_fmt_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fmtOneHot));

  p_bj_imm_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fmtOneHot[FMT_B] || fmtOneHot[FMT_J]) |-> (immOut[0] == 1'b0));

  p_u_imm_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    fmtOneHot[FMT_U] |-> (immOut[11:0] == 12'h000));

  p_no_fmt_imm_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fmtOneHot == '0) |-> (immOut == '0));

  p_r_fields_r6: assert property (@(posedge clk) disable iff (!rstN)
    fmtOneHot[FMT_R] |-> (rs1Vld && rs2Vld && rdVld && funct3Vld && funct7Vld));

  p_f7_only_r_r6: assert property (@(posedge clk) disable iff (!rstN)
    funct7Vld |-> fmtOneHot[FMT_R]);

  p_rd_not_sb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fmtOneHot[FMT_S] || fmtOneHot[FMT_B]) |-> !rdVld);

  p_invalid_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((rs1Vld || rs1Out == '0) && (rs2Vld || rs2Out == '0) && (rdVld || rdOut == '0) &&
     (funct3Vld || funct3Out == '0) && (funct7Vld || funct7Out == '0)));

  p_branch_fmt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brMatch != '0) |-> (fmtOneHot[FMT_B] && $onehot0(brMatch)));

  p_add_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(isAddImm && isAddReg));

  p_add_fmt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isAddImm |-> fmtOneHot[FMT_I]) and (isAddReg |-> fmtOneHot[FMT_R]));

  if (OUT_REG) begin : g_regChk
    logic armed;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) armed <= 1'b0;
      else       armed <= 1'b1;
    end

    p_opcode_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
      armed |-> (opcodeOut == $past(instrIn[6:0])));

    p_reset_clear_r10: assert property (@(posedge clk)
      !rstN |-> (fmtOneHot == '0 && immOut == '0 && brMatch == '0 && opcodeOut == '0 &&
                 !isAddImm && !isAddReg && !rs1Vld && !rdVld));
  end
endmodule

bind instr_decoder instr_decoder_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rstN(rstN), .instrIn(instrIn), .fmtOneHot(fmtOneHot), .immOut(immOut),
  .rs1Out(rs1Out), .rs2Out(rs2Out), .rdOut(rdOut), .funct3Out(funct3Out),
  .funct7Out(funct7Out), .opcodeOut(opcodeOut), .rs1Vld(rs1Vld), .rs2Vld(rs2Vld),
  .rdVld(rdVld), .funct3Vld(funct3Vld), .funct7Vld(funct7Vld), .brMatch(brMatch),
  .isAddImm(isAddImm), .isAddReg(isAddReg)
);

// File: tb/test_instr_decoder.sv
module test_instr_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrIn = 32'h0;
  logic [5:0]  fmtOneHot;
  logic [31:0] immOut;
  logic [4:0]  rs1Out, rs2Out, rdOut;
  logic [2:0]  funct3Out;
  logic [6:0]  funct7Out, opcodeOut;
  logic        rs1Vld, rs2Vld, rdVld, funct3Vld, funct7Vld;
  logic [5:0]  brMatch;
  logic        isAddImm, isAddReg;

  int nVec = 0;
  int nMis = 0;
  bit done = 0;
  logic [31:0] pendQ[$];

  typedef struct packed {
    logic [5:0]  fmt;
    logic [31:0] imm;
    logic [4:0]  rs1, rs2, rd;
    logic [2:0]  f3;
    logic [6:0]  f7, opc;
    logic        v1, v2, vd, vf3, vf7;
    logic [5:0]  br;
    logic        addi, add;
  } exp_t;

  always #4 clk = ~clk;  // 8 ns period

  instr_decoder i_instr_decoder (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .fmtOneHot(fmtOneHot), .immOut(immOut),
    .rs1Out(rs1Out), .rs2Out(rs2Out), .rdOut(rdOut), .funct3Out(funct3Out),
    .funct7Out(funct7Out), .opcodeOut(opcodeOut), .rs1Vld(rs1Vld), .rs2Vld(rs2Vld),
    .rdVld(rdVld), .funct3Vld(funct3Vld), .funct7Vld(funct7Vld), .brMatch(brMatch),
    .isAddImm(isAddImm), .isAddReg(isAddReg)
  );

  // behavioural reference built straight from the requirement text
  function automatic exp_t refDecode(logic [31:0] w);
    exp_t e;
    logic signed [31:0] sw;
    int k;
    e = '0;
    sw = w;
    k = -1;
    case (w[6:2])                                  // R1
      5'h0B, 5'h0C, 5'h0E, 5'h14:        k = 0;
      5'h00, 5'h01, 5'h04, 5'h06, 5'h19: k = 1;
      5'h08, 5'h09:                      k = 2;
      5'h18:                             k = 3;
      5'h05, 5'h0D:                      k = 4;
      5'h1B:                             k = 5;
      default:                           k = -1;
    endcase
    if (k >= 0) e.fmt[k] = 1'b1;
    case (k)                                       // R3 R4
      1: e.imm = 32'(sw >>> 20);
      2: e.imm = 32'((sw >>> 25) <<< 5) | 32'(w[11:7]);
      3: e.imm = 32'((sw >>> 31) <<< 12) | (32'(w[7]) << 11) | (32'(w[30:25]) << 5) | (32'(w[11:8]) << 1);
      4: e.imm = w & 32'hFFFF_F000;
      5: e.imm = 32'((sw >>> 31) <<< 20) | (32'(w[19:12]) << 12) | (32'(w[20]) << 11) | (32'(w[30:21]) << 1);
      default: e.imm = 32'h0;
    endcase
    e.v1  = (k == 0 || k == 1 || k == 2 || k == 3);  // R6
    e.vf3 = e.v1;
    e.v2  = (k == 0 || k == 2 || k == 3);
    e.vd  = (k == 0 || k == 1 || k == 4 || k == 5);
    e.vf7 = (k == 0);
    e.rs1 = e.v1  ? w[19:15] : 5'h0;               // R5 R7
    e.rs2 = e.v2  ? w[24:20] : 5'h0;
    e.rd  = e.vd  ? w[11:7]  : 5'h0;
    e.f3  = e.vf3 ? w[14:12] : 3'h0;
    e.f7  = e.vf7 ? w[31:25] : 7'h0;
    e.opc = w[6:0];
    if (w[6:0] == 7'h63) begin                     // R8
      case (w[14:12])
        3'd0: e.br[0] = 1'b1;
        3'd1: e.br[1] = 1'b1;
        3'd4: e.br[2] = 1'b1;
        3'd5: e.br[3] = 1'b1;
        3'd6: e.br[4] = 1'b1;
        3'd7: e.br[5] = 1'b1;
        default: ;
      endcase
    end
    e.addi = (w[6:0] == 7'h13) && (w[14:12] == 3'd0);               // R9
    e.add  = (w[6:0] == 7'h33) && (w[14:12] == 3'd0) && !w[30];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp, input logic [31:0] w);
    if (got !== exp) begin
      nMis++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, got, exp);
    end
  endtask

  task automatic compareAll(input exp_t e, input logic [31:0] w);
    nVec++;
    chk("R1 format", 32'(fmtOneHot), 32'(e.fmt), w);
    chk("R2 onehot", 32'($countones(fmtOneHot) <= 1), 32'd1, w);
    chk("R3 R4 immediate", immOut, e.imm, w);
    chk("R5 R7 rs1", 32'(rs1Out), 32'(e.rs1), w);
    chk("R5 R7 rs2", 32'(rs2Out), 32'(e.rs2), w);
    chk("R5 R7 rd", 32'(rdOut), 32'(e.rd), w);
    chk("R5 R7 funct3", 32'(funct3Out), 32'(e.f3), w);
    chk("R5 R7 funct7", 32'(funct7Out), 32'(e.f7), w);
    chk("R5 opcode", 32'(opcodeOut), 32'(e.opc), w);
    chk("R6 valids", 32'({rs1Vld, rs2Vld, rdVld, funct3Vld, funct7Vld}),
        32'({e.v1, e.v2, e.vd, e.vf3, e.vf7}), w);
    chk("R8 branch", 32'(brMatch), 32'(e.br), w);
    chk("R9 addi", 32'(isAddImm), 32'(e.addi), w);
    chk("R9 add", 32'(isAddReg), 32'(e.add), w);
  endtask

  task automatic checkReset(input string ctx);
    nVec++;
    chk({"R10 reset ", ctx},
        32'({fmtOneHot, brMatch, opcodeOut, rs1Vld, rs2Vld, rdVld, funct3Vld, funct7Vld, isAddImm, isAddReg}),
        32'h0, instrIn);
    chk({"R10 reset imm ", ctx}, immOut, 32'h0, instrIn);
    chk({"R10 reset fields ", ctx}, 32'({rs1Out, rs2Out, rdOut, funct3Out, funct7Out}), 32'h0, instrIn);
  endtask

  // drive at a falling edge; the register captures at the next rising edge
  task automatic apply(input logic [31:0] w);
    exp_t e;
    logic [31:0] old;
    instrIn = w;
    pendQ.push_back(w);
    @(negedge clk);
    old = pendQ.pop_front();
    e = refDecode(old);
    compareAll(e, old);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nMis++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [6:0] typOpc [9];
    typOpc = '{7'h33, 7'h13, 7'h03, 7'h67, 7'h23, 7'h63, 7'h37, 7'h17, 7'h6F};
    instrIn = 32'hFFFF_FFB3;        // reset must hide even a busy word
    repeat (3) @(negedge clk);
    checkReset("held");
    rstN = 1'b1;

    // every opcode group, random upper bits (R1 R2 R5 R6 R7)
    for (int g = 0; g < 32; g++) apply({$urandom()} & 32'hFFFF_FF80 | 32'(g << 2) | 32'h3);

    // immediate sign corners per format (R3 R4)
    for (int t = 0; t < 9; t++) begin
      apply(32'h8000_0000 | 32'(typOpc[t]));
      apply(32'h7FFF_FF80 | 32'(typOpc[t]));
      apply(32'hFFFF_FF80 | 32'(typOpc[t]));
    end
    apply(32'hFFFF_FFFF);           // no format: immediate zero (R4)

    // branch kinds, including undefined funct3 and bit 30 set (R8)
    for (int f = 0; f < 8; f++) begin
      apply(32'(f << 12) | 32'h0000_0063 | 32'h0123_4080);
      apply(32'(f << 12) | 32'h4000_0063);
    end
    apply(32'h0000_0073 | 32'h0000_0000);   // system group: no branch

    // add-immediate and register add keys (R9)
    apply(32'h0010_0093);            // add-immediate
    apply(32'h4010_0093);            // bit 30 set, still add-immediate
    apply(32'h0020_81B3);            // register add
    apply(32'h4020_81B3);            // bit 30 set: not register add
    apply(32'h0220_81B3);            // other funct7 bits ignored: still add
    apply(32'h0020_91B3);            // funct3 nonzero: no add

    // random words of every format and fully random words
    for (int n = 0; n < 3000; n++) begin
      if (n % 2 == 0) apply(({$urandom()} & 32'hFFFF_FF80) | 32'(typOpc[$urandom_range(0, 8)]));
      else            apply($urandom());
    end

    // asynchronous reset in mid-run clears outputs (R10)
    instrIn = 32'h0020_81B3;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkReset("mid-run");
    finishRun();
  end
endmodule